// File: doc/BRIEF.md
# Completion-to-Payload Ordering Gate

This block sits on the card-to-host streaming path, between a packet source and the DMA engine. Data packets pass straight through on an AXI4-Stream style channel. Each packet that is not dropped receives a running 16-bit identifier. The identifier starts at 1, stays constant for every beat of its packet, and advances by one when the final beat leaves the block. Completion requests arrive on a separate channel and enter a small in-order FIFO. A completion of payload kind names the identifier of the data packet it reports. It stays at the FIFO head until that packet has fully left the output, and only then is it released.

Completions of immediate kind and marker kind carry no payload and consume no descriptor. They leave as soon as they reach the FIFO head. The block records, per packet, whether the packet was flagged as having a completion. A payload completion that names a packet sent without that flag is discarded and counted as an orphan, so flagged packets and payload completions stay paired one to one.

A zero-byte packet is a single beat that carries the last flag and reports every byte of the word as empty. Such a packet is dropped unless the zero-length mode input is set. That input is meant for use in simple-bypass operation.

Top module: `cpg_order_gate`

## Requirements
- R1: The output `m_dat_pkt_id` shows 1 for the first forwarded packet. It is constant over all beats of a packet and increases by one, modulo 2^16, after each final beat that is transferred on the output.
- R2: A data beat that is not dropped appears on the output in the same cycle with data, last, empty count and completion flag unchanged, and `s_dat_ready` equals `m_dat_ready`.
- R3: A completion of kind 0 (payload) is held until the packet whose identifier equals its wait-id has had its final beat transferred. It may leave from the next cycle on. A packet counts as done while (last_done_id - wait_id) mod 2^16 is below 2^15.
- R4: A completion of kind 1 (immediate), kind 2 (marker) or kind 3 is offered on the output as soon as it is at the FIFO head, with no wait.
- R5: Completions leave in the order they were accepted. An offered completion keeps its kind and user field until it is taken.
- R6: The completion FIFO holds `CMP_DEPTH` entries, and `s_cmp_ready` is low exactly while all of them are occupied.
- R7: A payload completion whose named packet left with its completion flag at 0 is removed without being offered. `orphan_pulse` is high in that cycle, and `orphan_cnt` increases by one, saturating at its maximum.
- R8: With `zero_len_ok` at 0, a first beat that has last set and an empty count equal to the bytes per word is accepted, is not forwarded, consumes no identifier, and raises `zlen_drop` for that cycle.
- R9: With `zero_len_ok` at 1, such a zero-byte beat is forwarded and numbered like any other packet.
- R10: When each flagged packet is named by exactly one payload completion, the number of payload completions emitted equals the number of flagged packets.
- R11: After reset the next identifier is 1, no completion is offered, `s_cmp_ready` is high and `orphan_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| zero_len_ok | input | 1 | 1 lets zero-byte packets through (simple-bypass setting) |
| s_dat_valid | input | 1 | Input data beat valid |
| s_dat_ready | output | 1 | Input data beat accepted |
| s_dat_data | input | DATA_W | Input data word |
| s_dat_last | input | 1 | Final beat of the packet |
| s_dat_empty | input | clog2(DATA_W/8+1) | Unused bytes on the final beat |
| s_dat_has_cmpt | input | 1 | Packet is paired with a payload completion (sampled on final beat) |
| m_dat_valid | output | 1 | Output data beat valid |
| m_dat_ready | input | 1 | Downstream accepts data |
| m_dat_data | output | DATA_W | Output data word |
| m_dat_last | output | 1 | Final beat of the packet |
| m_dat_empty | output | clog2(DATA_W/8+1) | Unused bytes on the final beat |
| m_dat_has_cmpt | output | 1 | Completion flag passed through |
| m_dat_pkt_id | output | ID_W | Running identifier of the current packet |
| zlen_drop | output | 1 | A zero-byte beat was dropped this cycle |
| s_cmp_valid | input | 1 | Completion request valid |
| s_cmp_ready | output | 1 | Completion request accepted |
| s_cmp_kind | input | 2 | 0 payload, 1 immediate, 2 marker, 3 other non-payload |
| s_cmp_wait_id | input | ID_W | Identifier of the packet a payload completion waits for |
| s_cmp_user | input | USER_W | Opaque completion content |
| m_cmp_valid | output | 1 | Completion released |
| m_cmp_ready | input | 1 | Downstream takes the completion |
| m_cmp_kind | output | 2 | Kind of the released completion |
| m_cmp_user | output | USER_W | Content of the released completion |
| orphan_pulse | output | 1 | A payload completion was discarded this cycle |
| orphan_cnt | output | ERR_W | Saturating count of discarded payload completions |

## Verification
The assertions rely on one input assumption. A payload completion must reach the FIFO head within `FLAG_WIN` packets of the packet it names, because the per-packet flags are kept only for that recent window. A released completion also keeps its offer only if that window is not overrun while it waits. The stimulus keeps this bound: every payload completion is pushed just before or just after its own packet, and the queue stays a few entries deep. The identifier-wrap test runs more than 2^16 packets without any completion in flight. It then names packets only on either side of the wrap point.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef enum logic [1:0] {
    CK_PAYLOAD = 2'd0,
    CK_IMMED   = 2'd1,
    CK_MARKER  = 2'd2,
    CK_OTHER   = 2'd3
  } cmp_kind_e;
endpackage

// File: rtl/cpg_pkt_numberer.sv
module cpg_pkt_numberer #(
  parameter int DATA_W   = 64,
  parameter int ID_W     = 16,
  parameter int FLAG_WIN = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              zero_len_ok,
  input  logic                              s_valid,
  input  logic                              s_last,
  input  logic [$clog2(DATA_W/8+1)-1:0]     s_empty,
  input  logic                              s_has_cmpt,
  input  logic                              m_ready,
  output logic                              s_ready,
  output logic                              m_valid,
  output logic [ID_W-1:0]                   pkt_id,
  output logic                              zlen_drop,
  output logic [ID_W-1:0]                   done_id,
  input  logic [$clog2(FLAG_WIN)-1:0]       flag_idx,
  output logic                              flag_bit
);
  localparam int BYTES = DATA_W / 8;
  localparam int EMP_W = $clog2(BYTES + 1);
  localparam int WLG   = $clog2(FLAG_WIN);

  logic                in_pkt_q, in_pkt_d;
  logic [ID_W-1:0]     id_q, id_d;
  logic [ID_W-1:0]     done_q, done_d;
  logic [FLAG_WIN-1:0] flag_q, flag_d;
  logic                zero_beat, out_fire, upd_en;

  // zero-byte packet: opening beat that is also final and fully empty
  assign zero_beat = s_valid && !in_pkt_q && s_last &&
                     (s_empty == EMP_W'(BYTES)) && !zero_len_ok;
  assign m_valid   = s_valid && !zero_beat;
  assign s_ready   = zero_beat || m_ready;
  assign out_fire  = m_valid && m_ready;
  assign upd_en    = out_fire;
  assign zlen_drop = zero_beat;
  assign pkt_id    = id_q;
  assign done_id   = done_q;
  assign flag_bit  = flag_q[flag_idx];

  always_comb begin
    in_pkt_d = in_pkt_q;
    id_d     = id_q;
    done_d   = done_q;
    flag_d   = flag_q;
    if (out_fire) begin
      in_pkt_d = !s_last;
      if (s_last) begin
        id_d                = id_q + 1'b1;
        done_d              = id_q;
        flag_d[id_q[WLG-1:0]] = s_has_cmpt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      id_q     <= ID_W'(1);
      done_q   <= '0;
      flag_q   <= '0;
    end else if (upd_en) begin
      in_pkt_q <= in_pkt_d;
      id_q     <= id_d;
      done_q   <= done_d;
      flag_q   <= flag_d;
    end
  end

  // R1: identifier advances by one after a final beat leaves
  assert_id_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && s_last) |=> (pkt_id == $past(pkt_id) + 1'b1));
  // R1: identifier holds across the beats of one packet
  assert_id_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !s_last) |=> $stable(pkt_id));
  // R8: a dropped zero-byte beat consumes no identifier
  assert_zero_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zlen_drop |=> $stable(pkt_id));
endmodule

// File: rtl/cpg_cmp_fifo.sv
module cpg_cmp_fifo #(
  parameter int WIDTH = 26,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             head_valid,
  output logic [WIDTH-1:0] head_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_fire, ptr_en;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ready = (cnt_q != CW'(DEPTH));
  assign push_fire  = push_valid && push_ready;
  assign head_valid = (cnt_q != '0);
  assign head_data  = mem[rd_q];
  assign ptr_en     = push_fire || pop;

  always_comb begin
    wr_d  = push_fire ? step(wr_q) : wr_q;
    rd_d  = pop ? step(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push_fire && !pop) cnt_d = cnt_q + 1'b1;
    else if (!push_fire && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_q] <= push_data;
  end

  // R6: a full queue with no removal stays full, never wraps over
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CW'(DEPTH)) && !pop) |=> (cnt_q == CW'(DEPTH)));
  // R5: removal is only requested while an entry is present
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
endmodule

// File: rtl/cpg_release_ctl.sv
module cpg_release_ctl
  import cpg_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int WLG    = 4,
  parameter int USER_W = 8,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [1:0]        head_kind,
  input  logic [ID_W-1:0]   head_wait,
  input  logic [USER_W-1:0] head_user,
  input  logic [ID_W-1:0]   done_id,
  input  logic              flag_bit,
  output logic [WLG-1:0]    flag_idx,
  output logic              pop,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [1:0]        m_kind,
  output logic [USER_W-1:0] m_user,
  output logic              orphan,
  output logic [ERR_W-1:0]  err_cnt
);
  logic [ID_W-1:0]  gap;
  logic             is_pay, reached;
  logic [ERR_W-1:0] err_q, err_d;
  logic             err_en;

  assign is_pay   = (cmp_kind_e'(head_kind) == CK_PAYLOAD);
  assign gap      = done_id - head_wait;
  assign reached  = !gap[ID_W-1];
  assign flag_idx = head_wait[WLG-1:0];

  assign m_valid  = head_valid && (!is_pay || (reached && flag_bit));
  assign orphan   = head_valid && is_pay && reached && !flag_bit;
  assign pop      = (m_valid && m_ready) || orphan;
  assign m_kind   = head_kind;
  assign m_user   = head_user;
  assign err_cnt  = err_q;
  assign err_en   = orphan;

  always_comb begin
    err_d = err_q;
    if (err_q != '1) err_d = err_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  // R5: an offered completion holds until taken
  assert_hold_until_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_user) && $stable(m_kind)));
  // R7: each discard bumps the counter unless saturated
  assert_err_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (orphan && (err_cnt != '1)) |=> (err_cnt == $past(err_cnt) + 1'b1));
endmodule

// File: rtl/cpg_order_gate.sv
module cpg_order_gate #(
  parameter int DATA_W    = 64,
  parameter int ID_W      = 16,
  parameter int USER_W    = 8,
  parameter int CMP_DEPTH = 4,
  parameter int FLAG_WIN  = 16,
  parameter int ERR_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          zero_len_ok,
  input  logic                          s_dat_valid,
  output logic                          s_dat_ready,
  input  logic [DATA_W-1:0]             s_dat_data,
  input  logic                          s_dat_last,
  input  logic [$clog2(DATA_W/8+1)-1:0] s_dat_empty,
  input  logic                          s_dat_has_cmpt,
  output logic                          m_dat_valid,
  input  logic                          m_dat_ready,
  output logic [DATA_W-1:0]             m_dat_data,
  output logic                          m_dat_last,
  output logic [$clog2(DATA_W/8+1)-1:0] m_dat_empty,
  output logic                          m_dat_has_cmpt,
  output logic [ID_W-1:0]               m_dat_pkt_id,
  output logic                          zlen_drop,
  input  logic                          s_cmp_valid,
  output logic                          s_cmp_ready,
  input  logic [1:0]                    s_cmp_kind,
  input  logic [ID_W-1:0]               s_cmp_wait_id,
  input  logic [USER_W-1:0]             s_cmp_user,
  output logic                          m_cmp_valid,
  input  logic                          m_cmp_ready,
  output logic [1:0]                    m_cmp_kind,
  output logic [USER_W-1:0]             m_cmp_user,
  output logic                          orphan_pulse,
  output logic [ERR_W-1:0]              orphan_cnt
);
  localparam int WLG   = $clog2(FLAG_WIN);
  localparam int ENT_W = 2 + ID_W + USER_W;

  logic              rst_meta_q, rst_sync_q;
  logic [ID_W-1:0]   done_id;
  logic [WLG-1:0]    flag_idx;
  logic              flag_bit, pop, head_valid;
  logic [ENT_W-1:0]  head_ent;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign m_dat_data     = s_dat_data;
  assign m_dat_last     = s_dat_last;
  assign m_dat_empty    = s_dat_empty;
  assign m_dat_has_cmpt = s_dat_has_cmpt;

  cpg_pkt_numberer #(
    .DATA_W(DATA_W), .ID_W(ID_W), .FLAG_WIN(FLAG_WIN)
  ) numberer_i (
    .clk(clk), .rst_n(rst_sync_q), .zero_len_ok(zero_len_ok),
    .s_valid(s_dat_valid), .s_last(s_dat_last), .s_empty(s_dat_empty),
    .s_has_cmpt(s_dat_has_cmpt), .m_ready(m_dat_ready),
    .s_ready(s_dat_ready), .m_valid(m_dat_valid), .pkt_id(m_dat_pkt_id),
    .zlen_drop(zlen_drop), .done_id(done_id),
    .flag_idx(flag_idx), .flag_bit(flag_bit)
  );

  cpg_cmp_fifo #(
    .WIDTH(ENT_W), .DEPTH(CMP_DEPTH)
  ) fifo_i (
    .clk(clk), .rst_n(rst_sync_q),
    .push_valid(s_cmp_valid), .push_ready(s_cmp_ready),
    .push_data({s_cmp_kind, s_cmp_wait_id, s_cmp_user}),
    .pop(pop), .head_valid(head_valid), .head_data(head_ent)
  );

  cpg_release_ctl #(
    .ID_W(ID_W), .WLG(WLG), .USER_W(USER_W), .ERR_W(ERR_W)
  ) release_i (
    .clk(clk), .rst_n(rst_sync_q),
    .head_valid(head_valid),
    .head_kind(head_ent[ENT_W-1 -: 2]),
    .head_wait(head_ent[USER_W +: ID_W]),
    .head_user(head_ent[USER_W-1:0]),
    .done_id(done_id), .flag_bit(flag_bit), .flag_idx(flag_idx),
    .pop(pop), .m_valid(m_cmp_valid), .m_ready(m_cmp_ready),
    .m_kind(m_cmp_kind), .m_user(m_cmp_user),
    .orphan(orphan_pulse), .err_cnt(orphan_cnt)
  );

  // R4: a non-payload completion at the head is never held back
  assert_nopay_free_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (head_valid && (head_ent[ENT_W-1 -: 2] != 2'd0)) |-> m_cmp_valid);
endmodule

// File: tb/cpg_order_gate_tb.sv
module cpg_order_gate_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zero_len_ok = 1'b0;
  logic s_dat_valid = 1'b0, s_dat_last = 1'b0, s_dat_has_cmpt = 1'b0;
  logic [63:0] s_dat_data = '0;
  logic [3:0]  s_dat_empty = '0;
  logic m_dat_ready = 1'b1;
  logic s_cmp_valid = 1'b0;
  logic [1:0] s_cmp_kind = '0;
  logic [15:0] s_cmp_wait_id = '0;
  logic [7:0] s_cmp_user = '0;
  logic m_cmp_ready = 1'b1;
  logic s_dat_ready, m_dat_valid, m_dat_last, m_dat_has_cmpt, zlen_drop;
  logic [63:0] m_dat_data;
  logic [3:0]  m_dat_empty;
  logic [15:0] m_dat_pkt_id;
  logic s_cmp_ready, m_cmp_valid, orphan_pulse;
  logic [1:0] m_cmp_kind;
  logic [7:0] m_cmp_user, orphan_cnt;

  always #(CLK_P/2) clk = ~clk;

  cpg_order_gate dut_i (
    .clk(clk), .rst_n(rst_n), .zero_len_ok(zero_len_ok),
    .s_dat_valid(s_dat_valid), .s_dat_ready(s_dat_ready), .s_dat_data(s_dat_data),
    .s_dat_last(s_dat_last), .s_dat_empty(s_dat_empty), .s_dat_has_cmpt(s_dat_has_cmpt),
    .m_dat_valid(m_dat_valid), .m_dat_ready(m_dat_ready), .m_dat_data(m_dat_data),
    .m_dat_last(m_dat_last), .m_dat_empty(m_dat_empty), .m_dat_has_cmpt(m_dat_has_cmpt),
    .m_dat_pkt_id(m_dat_pkt_id), .zlen_drop(zlen_drop),
    .s_cmp_valid(s_cmp_valid), .s_cmp_ready(s_cmp_ready), .s_cmp_kind(s_cmp_kind),
    .s_cmp_wait_id(s_cmp_wait_id), .s_cmp_user(s_cmp_user),
    .m_cmp_valid(m_cmp_valid), .m_cmp_ready(m_cmp_ready), .m_cmp_kind(m_cmp_kind),
    .m_cmp_user(m_cmp_user), .orphan_pulse(orphan_pulse), .orphan_cnt(orphan_cnt)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic ck(input longint act, input longint exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int kind; int wid; int user; } ent_t;
  ent_t cq[$];
  bit   fl[int];
  int   mdl_id = 1, mdl_done = 0, mdl_err = 0, obs_pay = 0;
  bit   mdl_inpkt = 1'b0, run_model = 1'b0;

  always @(negedge clk) begin
    if (run_model) begin
      bit zb, e_mv, e_cv, e_orph, push_ok;
      zb = s_dat_valid && !mdl_inpkt && s_dat_last && (s_dat_empty == 4'd8) && !zero_len_ok;
      e_mv = s_dat_valid && !zb;
      ck(m_dat_valid, e_mv, "R2/R8 m_dat_valid");
      ck(s_dat_ready, zb || m_dat_ready, "R2 s_dat_ready");
      ck(zlen_drop, zb, "R8 zlen_drop");
      if (e_mv) begin
        ck(m_dat_pkt_id, mdl_id, "R1 m_dat_pkt_id");
        ck(m_dat_data, s_dat_data, "R2 m_dat_data");
        ck({m_dat_last, m_dat_empty, m_dat_has_cmpt},
           {s_dat_last, s_dat_empty, s_dat_has_cmpt}, "R2 sideband");
      end
      e_cv = 1'b0; e_orph = 1'b0;
      if (cq.size() > 0) begin
        if (cq[0].kind != 0) e_cv = 1'b1;
        else if (((mdl_done - cq[0].wid) & 16'hFFFF) < 32768) begin
          if (fl.exists(cq[0].wid) && fl[cq[0].wid]) e_cv = 1'b1;
          else e_orph = 1'b1;
        end
      end
      ck(m_cmp_valid, e_cv, "R3/R4 m_cmp_valid");
      ck(orphan_pulse, e_orph, "R7 orphan_pulse");
      ck(orphan_cnt, mdl_err, "R7 orphan_cnt");
      ck(s_cmp_ready, cq.size() < DEPTH, "R6 s_cmp_ready");
      if (e_cv) begin
        ck(m_cmp_kind, cq[0].kind, "R5 m_cmp_kind");
        ck(m_cmp_user, cq[0].user, "R5 m_cmp_user");
      end
      push_ok = s_cmp_valid && (cq.size() < DEPTH);
      if ((e_cv && m_cmp_ready) || e_orph) begin
        if (e_cv && m_cmp_ready && cq[0].kind == 0) obs_pay++;
        if (e_orph && mdl_err < 255) mdl_err++;
        void'(cq.pop_front());
      end
      if (push_ok) cq.push_back('{int'(s_cmp_kind), int'(s_cmp_wait_id), int'(s_cmp_user)});
      if (e_mv && m_dat_ready) begin
        mdl_inpkt = !s_dat_last;
        if (s_dat_last) begin
          fl[mdl_id] = s_dat_has_cmpt;
          mdl_done = mdl_id;
          mdl_id = (mdl_id + 1) & 16'hFFFF;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  int  tb_id = 1, exp_pay = 0;
  bit  rand_en = 1'b0;

  initial begin
    forever begin
      @(posedge clk); #1;
      if (rand_en) begin
        m_dat_ready = 1'($urandom % 2);
        m_cmp_ready = 1'($urandom % 2);
      end
    end
  end

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic send_pkt(input int nbeats, input bit flag, input int emp);
    for (int b = 0; b < nbeats; b++) begin
      bit ok;
      s_dat_valid = 1'b1;
      s_dat_data = {$urandom, $urandom};
      s_dat_last = (b == nbeats - 1);
      s_dat_empty = (b == nbeats - 1) ? 4'(emp) : 4'd0;
      s_dat_has_cmpt = flag;
      do begin
        @(negedge clk); ok = s_dat_ready;
        @(posedge clk); #1;
      end while (!ok);
    end
    s_dat_valid = 1'b0;
    tb_id = (tb_id + 1) & 16'hFFFF;
  endtask

  task automatic push_cmp(input int kind, input int wid, input int user);
    bit ok;
    s_cmp_valid = 1'b1;
    s_cmp_kind = 2'(kind);
    s_cmp_wait_id = 16'(wid);
    s_cmp_user = 8'(user);
    do begin
      @(negedge clk); ok = s_cmp_ready;
      @(posedge clk); #1;
    end while (!ok);
    s_cmp_valid = 1'b0;
  endtask

  task automatic drain();
    while (cq.size() != 0) settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 run_model = 1'b1;
    // R11 reset state
    @(negedge clk);
    ck(m_dat_pkt_id, 1, "R11 first id");
    ck(m_cmp_valid, 0, "R11 no completion");
    ck(s_cmp_ready, 1, "R11 fifo ready");
    ck(orphan_cnt, 0, "R11 orphan count");
    settle();

    // R4 immediate passes with no packet
    push_cmp(1, 0, 8'h11);
    @(negedge clk); ck(m_cmp_valid, 1, "R4 immediate offered");
    settle();

    // R3 payload waits for packet 2
    push_cmp(0, 2, 8'h22); exp_pay++;
    send_pkt(2, 1'b0, 3);
    @(negedge clk); ck(m_cmp_valid, 0, "R3 held after packet 1");
    settle();
    send_pkt(3, 1'b1, 0);
    @(negedge clk); ck(m_cmp_valid, 1, "R3 released after packet 2");
    settle();
    drain();

    // R5 marker stays behind a waiting payload
    push_cmp(0, 3, 8'h33); exp_pay++;
    push_cmp(2, 0, 8'h44);
    @(negedge clk); ck(m_cmp_valid, 0, "R5 marker blocked behind payload");
    settle();
    send_pkt(1, 1'b1, 5);
    drain();

    // R7 orphan: packet 4 unflagged
    send_pkt(2, 1'b0, 1);
    push_cmp(0, 4, 8'h55);
    drain();
    @(negedge clk); ck(orphan_cnt, 1, "R7 orphan counted");
    settle();

    // R8 zero-byte drop, R9 zero-byte pass
    zero_len_ok = 1'b0;
    s_dat_valid = 1'b1; s_dat_last = 1'b1; s_dat_empty = 4'd8; s_dat_has_cmpt = 1'b0;
    @(negedge clk); ck(m_dat_valid, 0, "R8 zero-byte not forwarded");
    ck(zlen_drop, 1, "R8 zlen_drop");
    settle();
    s_dat_valid = 1'b0;
    send_pkt(1, 1'b0, 0);
    zero_len_ok = 1'b1;
    s_dat_valid = 1'b1; s_dat_last = 1'b1; s_dat_empty = 4'd8;
    @(negedge clk); ck(m_dat_valid, 1, "R9 zero-byte forwarded");
    ck(m_dat_pkt_id, 6, "R9 zero-byte numbered");
    settle();
    s_dat_valid = 1'b0; tb_id = 7; zero_len_ok = 1'b0;

    // R6 fifo full back-pressure
    m_cmp_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin push_cmp(0, 7 + i, 8'h60 + i); exp_pay++; end
    @(negedge clk); ck(s_cmp_ready, 0, "R6 full fifo back-pressures");
    settle();
    for (int i = 0; i < DEPTH; i++) send_pkt(1 + i, 1'b1, i);
    m_cmp_ready = 1'b1;
    drain();

    // mixed traffic under random back-pressure
    rand_en = 1'b1;
    for (int it = 0; it < 300; it++) begin
      int r;
      r = $urandom % 4;
      if (r == 0) push_cmp(1 + ($urandom % 3), 0, it & 255);
      else if (r == 1) begin
        push_cmp(0, tb_id, it & 255); exp_pay++;
        send_pkt(1 + ($urandom % 4), 1'b1, $urandom % 8);
      end else begin
        int pid;
        pid = tb_id;
        send_pkt(1 + ($urandom % 4), 1'b1, $urandom % 8);
        push_cmp(0, pid, it & 255); exp_pay++;
      end
    end
    rand_en = 1'b0;
    settle();
    m_dat_ready = 1'b1; m_cmp_ready = 1'b1;
    drain();

    // R1 identifier wrap, R3 wrap-aware comparison
    for (int i = 0; i < 65540; i++) send_pkt(1, 1'b0, 0);
    push_cmp(0, tb_id, 8'hA5); exp_pay++;
    @(negedge clk); ck(m_cmp_valid, 0, "R3 held across identifier wrap");
    ck(m_dat_pkt_id, tb_id, "R1 identifier after wrap");
    settle();
    send_pkt(1, 1'b1, 0);
    @(negedge clk); ck(m_cmp_valid, 1, "R3 released after wrap");
    settle();
    drain();
    repeat (2) settle();
    ck(obs_pay, exp_pay, "R10 payload completions match flagged packets");
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end
endmodule